// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block takes a byte stream of 64-bit signed control messages, least significant byte first, from a coordinating server. A handle flag comes with each message's final byte and says whether a handle accompanies it. Each full message is classified as soon as its eighth byte arrives. The block then runs a fixed setup handshake: a protocol version, then the node's own identifier, then any number of table messages until a shared-memory marker (value -1) ends setup. The same table messages keep being accepted after setup.

The block keeps a bounded table of peers. Each peer has a count of registered event vectors. A message with a handle registers the next vector of the named peer: the Nth such message for a peer selects vector N-1. A message without a handle drops all vectors of that peer. The table starts at a fixed number of peers and grows when a message names a peer beyond it. Events leave the block as one-cycle strobes that carry the peer and the vector. Faults leave it as a one-cycle pulse with a code.

Top module: `peer_setup_seq`

## Requirements
- R1: Bytes are gathered least significant first. A message is acted on at the clock edge that takes its eighth byte, with the handle flag sampled at that byte. Results are visible after that edge. Seven bytes alone change no output. The byte count restarts after each message.
- R2: The first message must equal PROTO_VER (default 0) and carry no handle. Otherwise error code 1 is raised and setup fails.
- R3: The second message must carry no handle and lie in 0..65535. Otherwise error code 2 is raised and setup fails. When valid, its value appears on own_id_o.
- R4: When cfg_master_i is 1, an identifier other than 0 raises error code 3 and setup fails. Identifier 0 proceeds normally.
- R5: After the identifier, any value below -1 or above 65535 is rejected with error code 4.
- R6: The first marker (-1) after the identifier sets setup_done_o, which stays set until reset. A later marker raises error code 5 and changes nothing else.
- R7: peer_count_o resets to INIT_PEERS (16). A peer value at or above the count grows the count to value+1. A value at or above MAX_PEERS (32) raises error code 6 and leaves the count unchanged.
- R8: A peer message with a handle pulses conn_o. ev_peer_o carries the peer and ev_vec_o carries that peer's count before the message. The count then increments.
- R9: A connect to a peer whose count already equals NUM_VECTORS (4) raises error code 7 and leaves the count unchanged.
- R10: A peer message without a handle naming the own identifier raises error code 8. Any other peer pulses disc_o, with ev_vec_o equal to the count released, and its count becomes 0.
- R11: Any error raised before setup_done_o is set halts the block until reset. Later messages then produce no strobe and no error and change no output.
- R12: err_o is high for exactly one cycle per fault. err_code_o shows the code with the pulse and holds it afterwards. No connect or disconnect strobe fires in the same cycle as err_o.
- R13: After reset, setup_done_o, err_o, conn_o, disc_o and own_id_o are 0, all vector counts are 0 and peer_count_o is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_master_i | input | 1 | Node must hold identifier 0 |
| rx_valid_i | input | 1 | Byte strobe |
| rx_byte_i | input | 8 | Message byte |
| rx_handle_i | input | 1 | Handle present, sampled with the eighth byte |
| own_id_o | output | 16 | Accepted own identifier |
| setup_done_o | output | 1 | Handshake complete |
| err_o | output | 1 | One-cycle fault pulse |
| err_code_o | output | 4 | Code of the latest fault |
| peer_count_o | output | 6 | Current peer table size |
| vec_count_o | output | 96 | Per-peer vector counts, 3 bits per peer, peer 0 in the lowest bits |
| conn_o | output | 1 | Vector registered strobe |
| disc_o | output | 1 | Peer dropped strobe |
| ev_peer_o | output | 5 | Peer of the strobe |
| ev_vec_o | output | 3 | Vector assigned, or count released |

## Verification
A corrupted vector count shows up on vec_count_o in the cycle after the edge that caused it. It also shows up on the next strobe for that peer, as a wrong ev_vec_o or a spurious code 7. A wrong handshake state shows up at the very next message, as a missing or extra error pulse or a setup_done_o that sets at the wrong time. A wrong table size shows up on peer_count_o right away and on the next out-of-table message as an unexpected code 6. The scoreboard matches every strobe and pulse against an expected queue, so an event that is missing, extra or mislabelled is reported within one message.

// File: rtl/peer_seq_pkg.sv
package peer_seq_pkg;
  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_VERSION  = 4'd1,
    E_ID       = 4'd2,
    E_MASTER   = 4'd3,
    E_RANGE    = 4'd4,
    E_SHM_DUP  = 4'd5,
    E_TABLE    = 4'd6,
    E_VEC_FULL = 4'd7,
    E_DISC_OWN = 4'd8
  } err_e;

  typedef enum logic [2:0] {
    S_VER,
    S_ID,
    S_RUN,
    S_DONE,
    S_ERR
  } state_e;

  localparam int unsigned MSG_BYTES = 8;
  localparam int unsigned ID_MAX    = 65535;
endpackage

// File: rtl/msg_assembler.sv
module msg_assembler import peer_seq_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic [63:0] msg_o
);
  localparam int unsigned CNTW = $clog2(MSG_BYTES);

  logic [CNTW-1:0] cnt_q;
  logic [7:0]      buf_q [MSG_BYTES-1];

  assign done_o = valid_i && (cnt_q == CNTW'(MSG_BYTES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < MSG_BYTES-1; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[k] <= '0;
      else if (valid_i && cnt_q == CNTW'(k)) buf_q[k] <= byte_i;
    end
    assign msg_o[8*k +: 8] = buf_q[k];
  end
  // last byte goes straight through so the message acts on its final edge
  assign msg_o[63 -: 8] = byte_i;

  a_r1_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/msg_classify.sv
module msg_classify import peer_seq_pkg::*; #(
  parameter int unsigned MAX_PEERS = 32,
  parameter logic [63:0] PROTO_VER = 64'd0
) (
  input  logic [63:0] msg_i,
  output logic        ver_ok_o,
  output logic        marker_o,
  output logic        in_range_o,
  output logic        fits_o,
  output logic [15:0] value_o
);
  assign ver_ok_o   = (msg_i == PROTO_VER);
  assign marker_o   = (msg_i == '1);
  assign in_range_o = (msg_i[63:16] == '0);
  assign value_o    = msg_i[15:0];
  assign fits_o     = in_range_o && (32'(msg_i[15:0]) < MAX_PEERS);
endmodule

// File: rtl/peer_table.sv
module peer_table #(
  parameter int unsigned MAX_PEERS   = 32,
  parameter int unsigned INIT_PEERS  = 16,
  parameter int unsigned NUM_VECTORS = 4,
  localparam int unsigned PIW = $clog2(MAX_PEERS),
  localparam int unsigned PW  = $clog2(MAX_PEERS + 1),
  localparam int unsigned CW  = $clog2(NUM_VECTORS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PIW-1:0]        idx_i,
  input  logic                  grow_i,
  input  logic                  inc_i,
  input  logic                  clr_i,
  output logic [CW-1:0]         cnt_sel_o,
  output logic [PW-1:0]         peer_count_o,
  output logic [MAX_PEERS*CW-1:0] counts_o
);
  logic [CW-1:0] cnt_q [MAX_PEERS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     peer_count_o <= PW'(INIT_PEERS);
    else if (grow_i) peer_count_o <= PW'(idx_i) + PW'(1);
  end

  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_peer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[p] <= '0;
      else if (idx_i == PIW'(p)) begin
        if (clr_i)      cnt_q[p] <= '0;
        else if (inc_i) cnt_q[p] <= cnt_q[p] + 1'b1;
      end
    end
    assign counts_o[p*CW +: CW] = cnt_q[p];

    a_r9_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[p] <= CW'(NUM_VECTORS));
  end

  assign cnt_sel_o = cnt_q[idx_i];

  a_r7_count_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_count_o >= $past(peer_count_o));
  a_r10_inc_clr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && clr_i));
endmodule

// File: rtl/peer_setup_seq.sv
module peer_setup_seq import peer_seq_pkg::*; #(
  parameter int unsigned MAX_PEERS   = 32,
  parameter int unsigned INIT_PEERS  = 16,
  parameter int unsigned NUM_VECTORS = 4,
  parameter logic [63:0] PROTO_VER   = 64'd0,
  localparam int unsigned PIW = $clog2(MAX_PEERS),
  localparam int unsigned PW  = $clog2(MAX_PEERS + 1),
  localparam int unsigned CW  = $clog2(NUM_VECTORS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_master_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_byte_i,
  input  logic                    rx_handle_i,
  output logic [15:0]             own_id_o,
  output logic                    setup_done_o,
  output logic                    err_o,
  output logic [3:0]              err_code_o,
  output logic [PW-1:0]           peer_count_o,
  output logic [MAX_PEERS*CW-1:0] vec_count_o,
  output logic                    conn_o,
  output logic                    disc_o,
  output logic [PIW-1:0]          ev_peer_o,
  output logic [CW-1:0]           ev_vec_o
);
  state_e        state_q, state_d;
  logic          msg_done;
  logic [63:0]   msg;
  logic          ver_ok, marker, in_range, fits;
  logic [15:0]   value;
  logic [PIW-1:0] idx;
  logic [CW-1:0] cnt_sel;
  logic          grow, inc, clr;
  logic          conn_d, disc_d, err_d;
  err_e          code_d;
  logic [15:0]   own_id_d;

  msg_assembler u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .byte_i  (rx_byte_i),
    .done_o  (msg_done),
    .msg_o   (msg)
  );

  msg_classify #(.MAX_PEERS(MAX_PEERS), .PROTO_VER(PROTO_VER)) u_cls (
    .msg_i      (msg),
    .ver_ok_o   (ver_ok),
    .marker_o   (marker),
    .in_range_o (in_range),
    .fits_o     (fits),
    .value_o    (value)
  );

  assign idx = value[PIW-1:0];

  peer_table #(
    .MAX_PEERS(MAX_PEERS), .INIT_PEERS(INIT_PEERS), .NUM_VECTORS(NUM_VECTORS)
  ) u_tab (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (idx),
    .grow_i       (grow),
    .inc_i        (inc),
    .clr_i        (clr),
    .cnt_sel_o    (cnt_sel),
    .peer_count_o (peer_count_o),
    .counts_o     (vec_count_o)
  );

  always_comb begin
    state_d  = state_q;
    own_id_d = own_id_o;
    grow = 1'b0; inc = 1'b0; clr = 1'b0;
    conn_d = 1'b0; disc_d = 1'b0; err_d = 1'b0;
    code_d = E_NONE;
    if (msg_done) begin
      unique case (state_q)
        S_VER: begin
          if (ver_ok && !rx_handle_i) state_d = S_ID;
          else begin err_d = 1'b1; code_d = E_VERSION; end
        end
        S_ID: begin
          if (rx_handle_i || !in_range) begin
            err_d = 1'b1; code_d = E_ID;
          end else if (cfg_master_i && value != '0) begin
            err_d = 1'b1; code_d = E_MASTER;
          end else begin
            own_id_d = value;
            state_d  = S_RUN;
          end
        end
        S_RUN, S_DONE: begin
          if (marker) begin
            if (state_q == S_RUN) state_d = S_DONE;
            else begin err_d = 1'b1; code_d = E_SHM_DUP; end
          end else if (!in_range) begin
            err_d = 1'b1; code_d = E_RANGE;
          end else if (!fits) begin
            err_d = 1'b1; code_d = E_TABLE;
          end else begin
            // grow first, then judge the action, as the server expects
            grow = (PW'(idx) >= peer_count_o);
            if (rx_handle_i) begin
              if (cnt_sel >= CW'(NUM_VECTORS)) begin
                err_d = 1'b1; code_d = E_VEC_FULL;
              end else begin
                conn_d = 1'b1; inc = 1'b1;
              end
            end else if (value == own_id_o) begin
              err_d = 1'b1; code_d = E_DISC_OWN;
            end else begin
              disc_d = 1'b1; clr = 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (err_d && state_q != S_DONE) state_d = S_ERR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_VER;
      own_id_o   <= '0;
      err_o      <= 1'b0;
      err_code_o <= '0;
      conn_o     <= 1'b0;
      disc_o     <= 1'b0;
      ev_peer_o  <= '0;
      ev_vec_o   <= '0;
    end else begin
      state_q  <= state_d;
      own_id_o <= own_id_d;
      err_o    <= err_d;
      conn_o   <= conn_d;
      disc_o   <= disc_d;
      if (err_d) err_code_o <= code_d;
      if (conn_d || disc_d) begin
        ev_peer_o <= idx;
        ev_vec_o  <= cnt_sel;
      end
    end
  end

  assign setup_done_o = (state_q == S_DONE);

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_o |=> setup_done_o);
  a_r8_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conn_o |-> ev_vec_o < CW'(NUM_VECTORS));
  a_r12_err_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !conn_o && !disc_o);
  a_r12_conn_disc_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conn_o && disc_o));
  a_r4_master_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_done_o && cfg_master_i) |-> own_id_o == '0);
  a_r11_halt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERR) |=> (state_q == S_ERR) && !conn_o && !disc_o && !err_o);
endmodule

// File: tb/sim_peer_setup_seq.sv
module sim_peer_setup_seq;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b0;
  logic valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic handle = 1'b0;

  logic [15:0] own_id;
  logic        done, err, conn, disc;
  logic [3:0]  code;
  logic [5:0]  pcount;
  logic [95:0] vcounts;
  logic [4:0]  ev_peer;
  logic [2:0]  ev_vec;

  always #5 clk = ~clk;

  peer_setup_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(master),
    .rx_valid_i(valid), .rx_byte_i(byte_in), .rx_handle_i(handle),
    .own_id_o(own_id), .setup_done_o(done), .err_o(err), .err_code_o(code),
    .peer_count_o(pcount), .vec_count_o(vcounts),
    .conn_o(conn), .disc_o(disc), .ev_peer_o(ev_peer), .ev_vec_o(ev_vec)
  );

  typedef struct { int kind; int peer; int val; string req; } exp_t;
  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  string cur_req = "R11";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // kind: 0 connect, 1 disconnect, 2 error (val = code)
  task automatic expect_ev(input int kind, input int peer, input int val, input string req);
    exp_t e;
    e.kind = kind; e.peer = peer; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    int k, p, v;
    if (rst_n && (err || conn || disc)) begin
      k = err ? 2 : (conn ? 0 : 1);
      p = int'(ev_peer);
      v = err ? int'(code) : int'(ev_vec);
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected event kind=%0d peer=%0d val=%0d, expected none",
                 cur_req, k, p, v);
      end else begin
        e = q.pop_front();
        if (e.kind != k || (k != 2 && e.peer != p) || e.val != v) begin
          fails++;
          $display("FAIL %s event: actual kind=%0d peer=%0d val=%0d expected kind=%0d peer=%0d val=%0d",
                   e.req, k, p, v, e.kind, e.peer, e.val);
        end
      end
    end
  end

  task automatic send_part(input logic [63:0] v, input bit h, input int lo, input int hi);
    for (int b = lo; b <= hi; b++) begin
      @(negedge clk);
      valid   = 1'b1;
      byte_in = v[8*b +: 8];
      handle  = (b == 7) ? h : 1'b0;
    end
  endtask

  task automatic finish_msg(input string req);
    @(negedge clk);
    valid = 1'b0; handle = 1'b0;
    @(negedge clk);
    chk(q.size() == 0, req, "expected events outstanding", q.size(), 0);
    q.delete();
  endtask

  task automatic send(input logic [63:0] v, input bit h, input string req);
    cur_req = req;
    send_part(v, h, 0, 7);
    finish_msg(req);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; handle = 1'b0; master = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int vc(input int p);
    return int'(vcounts[p*CW +: CW]);
  endfunction

  localparam logic [63:0] MARK = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    // ---- main flow, non-master
    do_reset(1'b0);
    chk(done == 0 && err == 0 && conn == 0 && disc == 0, "R13", "reset strobes", done, 0);
    chk(pcount == 16, "R13", "reset peer count", pcount, 16);
    chk(own_id == 0, "R13", "reset own id", own_id, 0);
    chk(vcounts == '0, "R13", "reset vector counts", vcounts != '0, 0);

    send(64'd0, 1'b0, "R2");
    cur_req = "R1";
    send_part(64'd2, 1'b0, 0, 6);
    @(negedge clk); valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(own_id == 0, "R1", "own id after seven bytes", own_id, 0);
    send_part(64'd2, 1'b0, 7, 7);
    finish_msg("R1");
    chk(own_id == 2, "R3", "own id accepted", own_id, 2);

    expect_ev(0, 1, 0, "R8"); send(64'd1, 1'b1, "R8");
    expect_ev(0, 1, 1, "R8"); send(64'd1, 1'b1, "R8");
    chk(vc(1) == 2, "R8", "peer 1 count", vc(1), 2);
    chk(done == 0, "R6", "done before marker", done, 0);

    expect_ev(0, 20, 0, "R7"); send(64'd20, 1'b1, "R7");
    chk(pcount == 21, "R7", "table grown", pcount, 21);

    send(MARK, 1'b0, "R6");
    chk(done == 1, "R6", "done after marker", done, 1);

    expect_ev(0, 1, 2, "R8"); send(64'd1, 1'b1, "R8");
    expect_ev(0, 1, 3, "R8"); send(64'd1, 1'b1, "R8");
    expect_ev(2, 0, 7, "R9"); send(64'd1, 1'b1, "R9");
    chk(vc(1) == 4, "R9", "count held at limit", vc(1), 4);
    chk(err == 0 && code == 7, "R12", "pulse ended, code held", {err, code}, 7);

    expect_ev(1, 1, 4, "R10"); send(64'd1, 1'b0, "R10");
    chk(vc(1) == 0, "R10", "count cleared", vc(1), 0);
    expect_ev(2, 0, 8, "R10"); send(64'd2, 1'b0, "R10");
    expect_ev(1, 25, 0, "R10"); send(64'd25, 1'b0, "R10");
    chk(pcount == 26, "R7", "grown by disconnect", pcount, 26);

    expect_ev(2, 0, 5, "R6"); send(MARK, 1'b0, "R6");
    expect_ev(2, 0, 6, "R7"); send(64'd40, 1'b0, "R7");
    chk(pcount == 26, "R7", "no growth past limit", pcount, 26);
    expect_ev(2, 0, 4, "R5"); send(64'd70000, 1'b0, "R5");
    expect_ev(2, 0, 4, "R5"); send(-64'sd5, 1'b1, "R5");
    chk(done == 1, "R6", "done kept after errors", done, 1);
    expect_ev(0, 1, 0, "R8"); send(64'd1, 1'b1, "R8");

    // ---- bad version then halt
    do_reset(1'b0);
    expect_ev(2, 0, 1, "R2"); send(64'd5, 1'b0, "R2");
    send(64'd0, 1'b0, "R11");
    send(64'd3, 1'b1, "R11");
    send(MARK, 1'b0, "R11");
    chk(done == 0 && own_id == 0 && vcounts == '0, "R11", "halted outputs", done, 0);

    do_reset(1'b0);
    expect_ev(2, 0, 1, "R2"); send(64'd0, 1'b1, "R2");

    // ---- identifier faults
    do_reset(1'b0);
    send(64'd0, 1'b0, "R2");
    expect_ev(2, 0, 2, "R3"); send(64'd70000, 1'b0, "R3");
    do_reset(1'b0);
    send(64'd0, 1'b0, "R2");
    expect_ev(2, 0, 2, "R3"); send(64'd4, 1'b1, "R3");
    chk(own_id == 0, "R3", "id with handle not taken", own_id, 0);

    // ---- master
    do_reset(1'b1);
    send(64'd0, 1'b0, "R2");
    expect_ev(2, 0, 3, "R4"); send(64'd3, 1'b0, "R4");
    send(MARK, 1'b0, "R11");
    chk(done == 0, "R4", "master fault halts", done, 0);
    do_reset(1'b1);
    send(64'd0, 1'b0, "R2");
    send(64'd0, 1'b0, "R4");
    send(MARK, 1'b0, "R4");
    chk(done == 1 && own_id == 0, "R4", "master id 0 completes", done, 1);

    // ---- range fault during setup halts
    do_reset(1'b0);
    send(64'd0, 1'b0, "R2");
    send(64'd7, 1'b0, "R3");
    expect_ev(2, 0, 4, "R5"); send(-64'sd2, 1'b0, "R5");
    send(MARK, 1'b0, "R11");
    send(64'd1, 1'b1, "R11");
    chk(done == 0 && vc(1) == 0, "R11", "halted after range fault", done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule